// File: doc/BRIEF.md
# Two-Level Page Table Walker

This unit translates a 32-bit virtual address into a 32-bit physical address. It walks a two-level page table that sits in memory. A request carries the virtual address, a read/write flag and a physical pointer to the top-level table. The pointer is already physical, so the first fetch needs no translation. The walker then reads one entry per level through a simple memory read port. It finishes with a one-cycle done strobe, the physical address and a fault code.

The virtual address is split into three fields. Bits [31:22] index the top-level table. Bits [21:12] index the leaf table. Bits [11:0] are the byte offset within the page. Each table fills exactly one 4 KiB page and holds 4-byte entries.

A successful walk costs two table reads. The data access that follows is left to the requester. Only one walk runs at a time.

Top module: `ptw_walker`

## Requirements
- R1: While reset is low and in the first cycle after it is released: `done` is 0, `mem_req` is 0, `fault` is 0 and `paddr` is 0.
- R2: The first table read goes to `{root_ptr[31:12], 12'h000} + 4 * vaddr[31:22]`. The low 12 bits of `root_ptr` have no effect on that address.
- R3: The second table read goes to `{top_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R4: An entry holds the frame number in bits [31:12] and the valid flag in bit 0. It holds the writable flag in bit 1, a use flag in bit 2 and a dirty flag in bit 3. Bits [11:4] are spare. The use, dirty and spare bits have no effect on any result.
- R5: If the top-level entry has bit 0 clear, the walk ends after exactly one table read. It reports fault code 1 (not present) with `paddr` = 0.
- R6: If the leaf entry has bit 0 clear, the walk ends after exactly two table reads. It reports fault code 1 with `paddr` = 0.
- R7: A write request whose leaf entry is valid with bit 1 clear ends with fault code 2 (protection) and `paddr` = 0. A read request to the same entry succeeds.
- R8: A walk with no fault reports fault code 0 and `paddr = {leaf_entry[31:12], vaddr[11:0]}`.
- R9: `done` lasts exactly one cycle. `mem_req` is low during `done`. While `mem_req` is high and `mem_rvalid` is low, both `mem_req` and `mem_addr` hold in the next cycle.
- R10: A request is taken only while the walker is idle. A `req_valid` seen during a walk or in the `done` cycle starts nothing and does not alter the result.
- R11: The writable flag of the top-level entry is ignored. A write whose path passes through a top-level entry with bit 1 clear still succeeds when the leaf permits it.
- R12: Fault code 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| root_ptr | input | 32 | Physical address of the top-level table (page aligned, bits [11:0] ignored) |
| mem_req | output | 1 | Table read request, held until data returns |
| mem_addr | output | 32 | Physical byte address of the entry being read |
| mem_rdata | input | 32 | Entry returned by memory |
| mem_rvalid | input | 1 | `mem_rdata` is valid this cycle |
| done | output | 1 | One-cycle strobe: result available |
| paddr | output | 32 | Translated physical address (0 on fault) |
| fault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
The bench sweeps every top-level index, every leaf index under one valid directory entry, and both access types. It checks each result against entries computed arithmetically. A walker that skipped the early exit on an invalid top-level entry would issue a second read and fail the read count. One that checked the writable flag at the wrong level would either fault writes that pass through read-only directories or let writes through to read-only leaves. Memory latency is varied, so a walker that dropped its address before data returned would be caught. Spare, use and dirty bits are set in patterns that would corrupt the frame number if the field were cut at the wrong place. A spurious `req_valid` is held across walks and through `done` to show that a new request is never taken early.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TOP,
        ST_LEAF,
        ST_DONE
    } st_e;

    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_WRITE_BIT = 1;
    localparam int PTE_USE_BIT   = 2;
    localparam int PTE_DIRTY_BIT = 3;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int AW    = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    parameter int ENT_B = 2
) (
    input  logic [AW-OFF_W-1:0] base_frame,
    input  logic [IDX_W-1:0]    idx,
    output logic [AW-1:0]       entry_addr
);
    localparam int SCALED_W = IDX_W + ENT_B;

    logic [SCALED_W-1:0] scaled;

    assign scaled     = {idx, {ENT_B{1'b0}}};
    assign entry_addr = {base_frame, {OFF_W{1'b0}}} + AW'(scaled);

endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PPN_W = 20,
    parameter bit LEAF  = 1'b0
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    output logic [PPN_W-1:0] frame,
    output flt_e             flt
);
    logic prot;

    assign frame = pte[PTE_W-1 -: PPN_W];

    generate
        if (LEAF) begin : g_leaf
            assign prot = is_write & ~pte[PTE_WRITE_BIT];
        end else begin : g_dir
            logic unused_dir;
            assign unused_dir = is_write ^ pte[PTE_WRITE_BIT];
            assign prot = 1'b0;
        end
    endgenerate

    logic unused_bits;
    assign unused_bits = ^pte[PTE_W-PPN_W-1:PTE_USE_BIT];

    always_comb begin
        if (!pte[PTE_VALID_BIT]) begin
            flt = FLT_ABSENT;
        end else if (prot) begin
            flt = FLT_PROT;
        end else begin
            flt = FLT_NONE;
        end
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int TOP_IDX_W = 10,
    parameter int LEAF_IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PTE_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [TOP_IDX_W+LEAF_IDX_W+OFF_W-1:0] req_vaddr,
    input  logic                            req_write,
    input  logic [TOP_IDX_W+LEAF_IDX_W+OFF_W-1:0] root_ptr,
    output logic                            mem_req,
    output logic [TOP_IDX_W+LEAF_IDX_W+OFF_W-1:0] mem_addr,
    input  logic [PTE_W-1:0]                mem_rdata,
    input  logic                            mem_rvalid,
    output logic                            done,
    output logic [TOP_IDX_W+LEAF_IDX_W+OFF_W-1:0] paddr,
    output logic [1:0]                      fault
);
    localparam int AW    = TOP_IDX_W + LEAF_IDX_W + OFF_W;
    localparam int PPN_W = AW - OFF_W;
    localparam int IDX_W = (TOP_IDX_W > LEAF_IDX_W) ? TOP_IDX_W : LEAF_IDX_W;

    typedef struct packed {
        st_e              st;
        logic [AW-1:0]    va;
        logic             wr;
        logic [PPN_W-1:0] base;
        logic [AW-1:0]    pa;
        flt_e             flt;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0] idx_sel;
    logic [PPN_W-1:0] top_frame, leaf_frame;
    flt_e             top_flt, leaf_flt;
    logic             unused_root;

    assign unused_root = ^root_ptr[OFF_W-1:0];

    always_comb begin
        if (r_q.st == ST_TOP) begin
            idx_sel = IDX_W'(r_q.va[AW-1 -: TOP_IDX_W]);
        end else begin
            idx_sel = IDX_W'(r_q.va[OFF_W +: LEAF_IDX_W]);
        end
    end

    ptw_entry_addr #(
        .AW   (AW),
        .OFF_W(OFF_W),
        .IDX_W(IDX_W),
        .ENT_B(2)
    ) u_addr (
        .base_frame(r_q.base),
        .idx       (idx_sel),
        .entry_addr(mem_addr)
    );

    ptw_pte_eval #(
        .PTE_W(PTE_W),
        .PPN_W(PPN_W),
        .LEAF (1'b0)
    ) u_top_eval (
        .pte     (mem_rdata),
        .is_write(r_q.wr),
        .frame   (top_frame),
        .flt     (top_flt)
    );

    ptw_pte_eval #(
        .PTE_W(PTE_W),
        .PPN_W(PPN_W),
        .LEAF (1'b1)
    ) u_leaf_eval (
        .pte     (mem_rdata),
        .is_write(r_q.wr),
        .frame   (leaf_frame),
        .flt     (leaf_flt)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va   = req_vaddr;
                    r_d.wr   = req_write;
                    r_d.base = root_ptr[AW-1:OFF_W];
                    r_d.pa   = '0;
                    r_d.flt  = FLT_NONE;
                    r_d.st   = ST_TOP;
                end
            end
            ST_TOP: begin
                if (mem_rvalid) begin
                    if (top_flt != FLT_NONE) begin
                        r_d.flt = top_flt;
                        r_d.pa  = '0;
                        r_d.st  = ST_DONE;
                    end else begin
                        r_d.base = top_frame;
                        r_d.st   = ST_LEAF;
                    end
                end
            end
            ST_LEAF: begin
                if (mem_rvalid) begin
                    r_d.flt = leaf_flt;
                    r_d.pa  = (leaf_flt == FLT_NONE) ?
                              {leaf_frame, r_q.va[OFF_W-1:0]} : '0;
                    r_d.st  = ST_DONE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, va: '0, wr: 1'b0, base: '0, pa: '0, flt: FLT_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req = (r_q.st == ST_TOP) || (r_q.st == ST_LEAF);
    assign done    = (r_q.st == ST_DONE);
    assign paddr   = r_q.pa;
    assign fault   = r_q.flt;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic          done,
    input logic [1:0]    fault
);
    // R9: strobe lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: request and address hold until data returns
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R9: no table read during the result cycle
    a_r9_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R10: an idle walker that sees a request starts a read next cycle
    a_r10_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_req && !done) |=> mem_req);

    // R12: reserved fault code never appears
    a_r12_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        fault != 2'd3);

endmodule

bind ptw_walker ptw_walker_chk #(.AW(TOP_IDX_W + LEAF_IDX_W + OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .done      (done),
    .fault     (fault)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] ROOT_PG = 20'h00040;
    localparam logic [19:0] L2_BASE = 20'h00100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] root_ptr = {ROOT_PG, 12'hABC};
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        done;
    logic [31:0] paddr;
    logic [1:0]  fault;

    int total = 0;
    int bad = 0;
    int lat = 0;
    int lat_cnt = 0;
    int nreads = 0;
    logic [31:0] rd_log [4];
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_vaddr (req_vaddr),
        .req_write (req_write),
        .root_ptr  (root_ptr),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_rvalid(mem_rvalid),
        .done      (done),
        .paddr     (paddr),
        .fault     (fault)
    );

    // Top-level entry i: frame L2_BASE+i, valid unless i%3==0, writable = i[0],
    // spare/use/dirty bits filled with noise (R4, R11)
    function automatic logic [31:0] top_pte(int i);
        logic [9:0] b = 10'(i);
        logic v = (i % 3) != 0;
        return {L2_BASE + 20'(i), b[7:0], b[1], b[2], b[0], v};
    endfunction

    function automatic logic [19:0] leaf_frame(int i, int j);
        return {10'(i), 10'(j)} ^ 20'h5A5A5;
    endfunction

    function automatic logic leaf_valid(int i, int j);
        return ((i + j) % 5) != 0;
    endfunction

    function automatic logic leaf_wr(int i, int j);
        return (i % 2) == (j % 2);
    endfunction

    function automatic logic [31:0] leaf_pte(int i, int j);
        logic [9:0] a = 10'(i);
        logic [9:0] b = 10'(j);
        return {leaf_frame(i, j), b[9:2], b[0], a[1], leaf_wr(i, j), leaf_valid(i, j)};
    endfunction

    function automatic logic [31:0] mem_f(logic [31:0] a);
        logic [19:0] pg = a[31:12];
        int w = int'(a[11:2]);
        if (pg == ROOT_PG) return top_pte(w);
        if (pg >= L2_BASE && pg < L2_BASE + 20'h400) return leaf_pte(int'(pg - L2_BASE), w);
        return 32'hDEAD_BEEF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_req && !mem_rvalid) begin
            if (lat_cnt >= lat) begin
                mem_rvalid <= 1'b1;
                mem_rdata <= mem_f(mem_addr);
                rd_log[nreads % 4] <= mem_addr;
                nreads <= nreads + 1;
                lat_cnt <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_rvalid <= 1'b0;
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic walk(int i, int j, int off, bit wr, bit junk);
        logic [31:0] va = {10'(i), 10'(j), 12'(off)};
        logic [31:0] exp_pa;
        logic [1:0]  exp_flt;
        int exp_n, n0, cyc, wid;
        if (top_pte(i)[0] == 1'b0) begin
            exp_flt = 2'd1; exp_pa = '0; exp_n = 1;          // R5
        end else if (!leaf_valid(i, j)) begin
            exp_flt = 2'd1; exp_pa = '0; exp_n = 2;          // R6
        end else if (wr && !leaf_wr(i, j)) begin
            exp_flt = 2'd2; exp_pa = '0; exp_n = 2;          // R7
        end else begin
            exp_flt = 2'd0; exp_pa = {leaf_frame(i, j), 12'(off)}; exp_n = 2;  // R8
        end
        lat = (i + j) % 3;
        @(negedge clk);
        n0 = nreads;
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        if (junk) begin
            req_vaddr = ~va; req_write = ~wr;                // R10 noise during walk
        end else begin
            req_valid = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, "R9 done timeout", {31'd0, done}, 32'd1);
        chk(mem_req == 1'b0, "R9 mem_req during done", {31'd0, mem_req}, 32'd0);
        chk(fault == exp_flt, "R5/R6/R7/R8/R11 fault", {30'd0, fault}, {30'd0, exp_flt});
        chk(paddr == exp_pa, "R8 paddr", paddr, exp_pa);
        chk(nreads - n0 == exp_n, "R5/R6 table reads", 32'(nreads - n0), 32'(exp_n));
        chk(rd_log[n0 % 4] == {ROOT_PG, 12'd0} + 32'(i * 4), "R2 top address",
            rd_log[n0 % 4], {ROOT_PG, 12'd0} + 32'(i * 4));
        if (exp_n == 2)
            chk(rd_log[(n0 + 1) % 4] == {L2_BASE + 20'(i), 12'd0} + 32'(j * 4), "R3 leaf address",
                rd_log[(n0 + 1) % 4], {L2_BASE + 20'(i), 12'd0} + 32'(j * 4));
        req_valid = 1'b0;
        @(negedge clk);
        wid = done ? 2 : 1;
        chk(wid == 1, "R9 done width", 32'(wid), 32'd1);
        chk(mem_req == 1'b0, "R10 request ignored while busy", {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && mem_req == 1'b0, "R1 reset strobes", {30'd0, done, mem_req}, 32'd0);
        chk(fault == 2'd0 && paddr == 32'd0, "R1 reset result", paddr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && mem_req == 1'b0 && fault == 2'd0 && paddr == 32'd0,
            "R1 after release", {28'd0, done, mem_req, fault}, 32'd0);
        // every top index; even valid entries are read-only directories (R11)
        for (int i = 0; i < 1024; i++)
            walk(i, (i * 7) % 1024, (i * 37) % 4096, i[1], (i % 4) == 0);
        // every leaf index under one directory, both access types (R4, R7)
        for (int j = 0; j < 1024; j++)
            walk(5, j, (j * 131) % 4096, j[0], 1'b0);
        for (int j = 0; j < 64; j++) begin
            walk(7, j, 12'hFFF, 1'b0, 1'b1);
            walk(7, j, 12'h000, 1'b1, 1'b0);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule